// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines and merges them into one interrupt signal for a processor. Each line feeds a request register, through either an edge detector or a level follower, and a mask register can block each line. A priority resolver compares the unmasked requests against the in-service register. It raises the interrupt output only when a request outranks every line already in service, so a more urgent line can nest above a less urgent one.

When the processor acknowledges, the winning line moves from the request register into the in-service register. An 8-bit vector is then shown: a programmable 5-bit base in the upper bits, and the 3-bit line index in the lower bits. Software finishes a handler with an end-of-interrupt command, which clears an in-service bit.

Priority can be fixed, with line 0 the most urgent. It can also rotate by itself, so that the line whose service just ended drops to the bottom. In the third scheme, software names the least urgent line and the rest follow around the ring. A small write port sets all of this.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, `int_out` is 0 and `vec_out` is 0. At reset the mask is clear, every line is edge triggered, the priority is fixed, the vector base is 0 and the lowest level is 7.
- R2: A line whose bit is 1 in the mask register (write address 0) never raises `int_out`, even while it is requesting.
- R3: With the fixed scheme (address 2 written with 0), the smaller line index wins, so line 0 is the most urgent.
- R4: With self-rotation (address 2 written with 1), a non-specific end-of-interrupt makes the line it clears the least urgent. The next line around the ring becomes the most urgent.
- R5: With software-chosen rotation (address 2 written with 2), the value written to address 4 names the least urgent line. Line (value+1) mod 8 is the most urgent, and the rest follow cyclically.
- R6: Trigger mode is set per line at address 1, with 1 meaning level and 0 meaning edge. An edge line latches a rising edge and keeps requesting after the line falls. A level line requests only while its input is high.
- R7: An acknowledge while `int_out` is 1 moves the winning line from the request register into the in-service register. From the next cycle, `vec_out` equals {base written at address 3 bits 4:0, winning index}.
- R8: A request is presented only if it outranks every in-service line. A request that is equal or lower in rank is held back.
- R9: Writing address 5 issues an end-of-interrupt. If bit 3 is 0, the most urgent in-service bit is cleared. If bit 3 is 1, the in-service bit named by bits 2:0 is cleared.
- R10: An acknowledge while `int_out` is 0 changes neither the in-service register nor `vec_out`.
- R11: A new rising edge on a line in the same cycle as that line's acknowledge leaves the line requesting again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, index 0 to 7 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address: 0 mask, 1 trigger, 2 scheme, 3 base, 4 lowest level, 5 end-of-interrupt |
| cfg_wdata | input | 8 | Configuration write data |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| int_out | output | 1 | Combined interrupt request to the processor |
| vec_out | output | 8 | Vector of the most recently acknowledged line |

## Verification
The acknowledge of an edge-triggered line and a fresh rising edge on that same line can land in the same clock edge. The bench provokes this by dropping line 1 after it is latched, then raising it again in the very cycle it drives the acknowledge. The result is judged from the outputs. `int_out` stays low while line 1 is in service, because an equal rank is held back. After a non-specific end-of-interrupt, `int_out` must rise again and a second acknowledge must return line 1's vector. This shows that the set from the edge wins over the clear from the acknowledge.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

   typedef enum logic [1:0] {
      PM_FIXED = 2'd0,
      PM_AUTO  = 2'd1,
      PM_SPEC  = 2'd2,
      PM_RSVD  = 2'd3
   } prio_mode_e;

   localparam logic [2:0] CFG_MASK = 3'd0;
   localparam logic [2:0] CFG_TRIG = 3'd1;
   localparam logic [2:0] CFG_MODE = 3'd2;
   localparam logic [2:0] CFG_BASE = 3'd3;
   localparam logic [2:0] CFG_LOW  = 3'd4;
   localparam logic [2:0] CFG_EOI  = 3'd5;

endpackage

// File: rtl/pic8_req_bank.sv
module pic8_req_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] trig_level,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] irr
);

   for (genvar g = 0; g < N; g++) begin : g_line
      logic prev_q;
      logic req_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            req_q  <= 1'b0;
         end else begin
            prev_q <= irq_in[g];
            if (trig_level[g])
               req_q <= irq_in[g] & ~ack_clr[g];
            else
               req_q <= (req_q & ~ack_clr[g]) | (irq_in[g] & ~prev_q);
         end
      end

      assign irr[g] = req_q;
   end

endmodule

// File: rtl/pic8_prio_pick.sv
module pic8_prio_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_vec,
   input  logic [IW-1:0] low_lvl,
   output logic          found,
   output logic [IW-1:0] win_idx,
   output logic [IW-1:0] win_rank
);

   if (N != (1 << IW)) begin : g_bad_n
      $error("pic8_prio_pick: N must be a power of two");
   end

   always_comb begin
      logic [IW-1:0] pos;
      found    = 1'b0;
      win_idx  = '0;
      win_rank = '0;
      pos      = '0;
      for (int k = N - 1; k >= 0; k--) begin
         pos = low_lvl + IW'(k + 1);
         if (req_vec[pos]) begin
            found    = 1'b1;
            win_idx  = pos;
            win_rank = IW'(k);
         end
      end
   end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
   import pic8_pkg::*;
#(
   parameter int N  = 8,
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  irq_in,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [VW-1:0] cfg_wdata,
   input  logic          int_ack,
   output logic          int_out,
   output logic [VW-1:0] vec_out
);

   localparam int IW = $clog2(N);
   localparam int BW = VW - IW;

   if (N != (1 << IW) || BW < 1 || VW < N || VW <= IW + 1) begin : g_bad_cfg
      $error("pic8_ctrl: illegal N/VW combination");
   end

   logic [N-1:0]  mask_q, trig_q, isr_q, irr;
   prio_mode_e    mode_q;
   logic [BW-1:0] base_q;
   logic [IW-1:0] low_q, eff_low;
   logic [VW-1:0] vec_q;

   logic          req_found, isr_found, present, ack_fire;
   logic [IW-1:0] req_idx, req_rank, isr_idx, isr_rank;
   logic [N-1:0]  ack_set, eoi_clr;
   logic          eoi_wr, eoi_spec;

   pic8_req_bank #(.N(N)) req_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .trig_level (trig_q),
      .ack_clr    (ack_set),
      .irr        (irr)
   );

   always_comb begin
      unique case (mode_q)
         PM_AUTO, PM_SPEC: eff_low = low_q;
         default:          eff_low = IW'(N - 1);
      endcase
   end

   pic8_prio_pick #(.N(N), .IW(IW)) pick_req_i (
      .req_vec  (irr & ~mask_q),
      .low_lvl  (eff_low),
      .found    (req_found),
      .win_idx  (req_idx),
      .win_rank (req_rank)
   );

   pic8_prio_pick #(.N(N), .IW(IW)) pick_isr_i (
      .req_vec  (isr_q),
      .low_lvl  (eff_low),
      .found    (isr_found),
      .win_idx  (isr_idx),
      .win_rank (isr_rank)
   );

   assign present  = req_found && (!isr_found || (req_rank < isr_rank));
   assign ack_fire = int_ack && present;
   assign ack_set  = ack_fire ? (N'(1) << req_idx) : '0;

   assign eoi_wr   = cfg_we && (cfg_addr == CFG_EOI);
   assign eoi_spec = cfg_wdata[IW];

   always_comb begin
      eoi_clr = '0;
      if (eoi_wr) begin
         if (eoi_spec)
            eoi_clr = N'(1) << cfg_wdata[IW-1:0];
         else if (isr_found)
            eoi_clr = N'(1) << isr_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         trig_q <= '0;
         mode_q <= PM_FIXED;
         base_q <= '0;
         low_q  <= IW'(N - 1);
         isr_q  <= '0;
         vec_q  <= '0;
      end else begin
         isr_q <= (isr_q & ~eoi_clr) | ack_set;
         if (ack_fire)
            vec_q <= {base_q, req_idx};
         if (cfg_we) begin
            unique case (cfg_addr)
               CFG_MASK: mask_q <= cfg_wdata[N-1:0];
               CFG_TRIG: trig_q <= cfg_wdata[N-1:0];
               CFG_MODE: mode_q <= prio_mode_e'(cfg_wdata[1:0]);
               CFG_BASE: base_q <= cfg_wdata[BW-1:0];
               CFG_LOW:  low_q  <= cfg_wdata[IW-1:0];
               default:  ;
            endcase
         end
         if (eoi_wr && !eoi_spec && isr_found && mode_q == PM_AUTO)
            low_q <= isr_idx;
      end
   end

   assign int_out = present;
   assign vec_out = vec_q;

endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
   parameter int N  = 8,
   parameter int VW = 8,
   parameter int IW = $clog2(N),
   parameter int BW = VW - IW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          int_ack,
   input logic          int_out,
   input logic          cfg_we,
   input logic [2:0]    cfg_addr,
   input logic [N-1:0]  isr_q,
   input logic [N-1:0]  irr,
   input logic [N-1:0]  mask_q,
   input logic [BW-1:0] base_q,
   input logic [VW-1:0] vec_out
);

   logic eoi_w;
   assign eoi_w = cfg_we && (cfg_addr == 3'd5);

   p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out && !eoi_w) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

   p_vec_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> (vec_out[VW-1:IW] == $past(base_q)));

   p_int_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (|(irr & ~mask_q)));

   p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_out && !cfg_we) |=> ((isr_q == $past(isr_q)) && $stable(vec_out)));

   p_eoi_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_w && !int_ack) |=> ($countones(isr_q) <= $past($countones(isr_q))));

endmodule

bind pic8_ctrl pic8_chk #(.N(N), .VW(VW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .int_ack  (int_ack),
   .int_out  (int_out),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .isr_q    (isr_q),
   .irr      (irr),
   .mask_q   (mask_q),
   .base_q   (base_q),
   .vec_out  (vec_out)
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       int_ack = 1'b0;
   logic       int_out;
   logic [7:0] vec_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pic8_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .int_ack   (int_ack),
      .int_out   (int_out),
      .vec_out   (vec_out)
   );

   // {scheme[1:0], lowest[2:0], mask[7:0], lines[7:0], exp_int, exp_vec[7:0]}, base 0x15
   localparam logic [29:0] TBL [6] = '{
      {2'd0, 3'd7, 8'h00, 8'h28, 1'b1, 8'hAB},  // R3 fixed: 3 beats 5
      {2'd0, 3'd7, 8'h08, 8'h28, 1'b1, 8'hAD},  // R2 line 3 masked
      {2'd2, 3'd4, 8'h00, 8'h09, 1'b1, 8'hA8},  // R5 lowest 4: 0 beats 3
      {2'd2, 3'd0, 8'h00, 8'h09, 1'b1, 8'hAB},  // R5 lowest 0: 3 beats 0
      {2'd2, 3'd2, 8'h00, 8'h84, 1'b1, 8'hAF},  // R5 lowest 2: 7 beats 2
      {2'd0, 3'd7, 8'hFF, 8'hFF, 1'b0, 8'h00}   // R2 all masked
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      irq_in = '0;
      int_ack = 1'b0;
      cfg_we = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic ack();
      int_ack = 1'b1;
      tick();
      int_ack = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      check("R1 int_out", 32'(int_out), 32'd0);
      check("R1 vec_out", 32'(vec_out), 32'd0);

      for (int i = 0; i < 6; i++) begin
         do_reset();
         wr(3'd3, 8'h15);
         wr(3'd2, {6'd0, TBL[i][29:28]});
         wr(3'd4, {5'd0, TBL[i][27:25]});
         wr(3'd0, TBL[i][24:17]);
         irq_in = TBL[i][16:9];
         tick();
         check("R2/R3/R5 table int_out", 32'(int_out), 32'(TBL[i][8]));
         if (TBL[i][8]) begin
            ack();
            check("R7 table vector", 32'(vec_out), 32'(TBL[i][7:0]));
         end
      end

      // R6 edge latch and level follow
      do_reset();
      wr(3'd3, 8'h15);
      irq_in = 8'h10; tick();
      irq_in = 8'h00; tick();
      check("R6 edge held", 32'(int_out), 32'd1);
      ack();
      check("R7 edge vector", 32'(vec_out), 32'hAC);
      do_reset();
      wr(3'd1, 8'h40);
      irq_in = 8'h40; tick();
      check("R6 level high", 32'(int_out), 32'd1);
      irq_in = 8'h00; tick();
      check("R6 level dropped", 32'(int_out), 32'd0);

      // R8 nesting, R9 end-of-interrupt
      do_reset();
      wr(3'd3, 8'h15);
      irq_in = 8'h20; tick();
      ack();
      check("R7 line5 vector", 32'(vec_out), 32'hAD);
      irq_in = 8'h60; tick();
      check("R8 lower held", 32'(int_out), 32'd0);
      irq_in = 8'h64; tick();
      check("R8 higher nests", 32'(int_out), 32'd1);
      ack();
      check("R8 nested vector", 32'(vec_out), 32'hAA);
      wr(3'd5, 8'h00);
      check("R9 non-specific keeps 5", 32'(int_out), 32'd0);
      wr(3'd5, 8'h0D);
      check("R9 specific clears 5", 32'(int_out), 32'd1);
      ack();
      check("R9 line6 vector", 32'(vec_out), 32'hAE);

      // R4 self-rotation
      do_reset();
      wr(3'd3, 8'h15);
      wr(3'd2, 8'h01);
      irq_in = 8'h09; tick();
      ack();
      check("R4 first winner", 32'(vec_out), 32'hA8);
      wr(3'd5, 8'h00);
      irq_in = 8'h08; tick();
      irq_in = 8'h09; tick();
      ack();
      check("R4 rotated winner", 32'(vec_out), 32'hAB);

      // R10 acknowledge with nothing presented
      check("R10 int_out low", 32'(int_out), 32'd0);
      ack();
      check("R10 vector unchanged", 32'(vec_out), 32'hAB);
      wr(3'd5, 8'h00);
      check("R10 line0 presented", 32'(int_out), 32'd1);
      ack();
      check("R10 line0 vector", 32'(vec_out), 32'hA8);

      // R11 ack and new edge on the same line, same cycle
      do_reset();
      wr(3'd3, 8'h15);
      irq_in = 8'h02; tick();
      irq_in = 8'h00; tick();
      irq_in = 8'h02;
      ack();
      check("R11 collision vector", 32'(vec_out), 32'hA9);
      check("R11 same level held", 32'(int_out), 32'd0);
      wr(3'd5, 8'h00);
      check("R11 request kept", 32'(int_out), 32'd1);
      ack();
      check("R11 second vector", 32'(vec_out), 32'hA9);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule